// File: doc/BRIEF.md
# Configuration Record Header Validator

This block checks a configuration record as it streams in from a serial EEPROM. It takes one byte per beat while `byte_vld_i` is high, starting at record offset 0, and judges the header on the fly. The header has a three-character identifier, a big-endian content length, a big-endian version number and a board-type code. The block also captures the six-byte Ethernet station address that sits at a fixed offset near the end of the record. Once the record has been received, it decides whether that address can be used as-is.

A controller pulses `start_i` before it begins reading. It then feeds the record bytes with any number of idle cycles between them, up to a bounded gap. After the last record byte, the block raises `done_o` for one cycle. From then until the next start, `rec_ok_o` and `mac_ok_o` hold the verdict. If the stream stops early, an idle-gap timer ends the read. `done_o` then fires with both verdicts low. The bus transaction that fetches the bytes is handled elsewhere, and the block computes no checksum.

Top module: `cfg_record_checker`

## Requirements
- R1: Record offsets 0, 1 and 2 must equal the three bytes of parameter `MAGIC`, with MAGIC[23:16] expected at offset 0. Any mismatch makes the record invalid.
- R2: Offsets 3 and 4 form the content length with offset 3 as the high byte. It is shown on `len_o`, and a record is valid only if the length is at least the record size minus 5 (65 with default parameters).
- R3: Offsets 5 to 7 form the version with offset 5 as the most significant byte. It is shown on `ver_o`, and only the values 1 and 2 are accepted.
- R4: Offset 8 holds the board-type code, and the record is valid only if it equals parameter `BOARD_TYPE` (default 2).
- R5: `done_o` is high for exactly one cycle: the cycle after the byte at offset `MAC_OFS+5` (0x45 by default) is accepted. From that cycle until the next start, `rec_ok_o` holds the combined result of R1 to R4.
- R6: The six bytes from offset `MAC_OFS` (default 0x40) are shown on `mac_o`, with the first of them in bits 47:40. The padding bytes at offsets 9 to `MAC_OFS-1` have no effect on any output.
- R7: `mac_ok_o` is high after done only if three conditions hold: the record is valid, `mac_o` is not all zeros, and bit 40 (the group-address bit of the first address byte) is clear.
- R8: While a record is being read, `GAP_LIMIT` consecutive cycles without `byte_vld_i` end the read. `done_o` rises after the `GAP_LIMIT`-th idle cycle, with `rec_ok_o` and `mac_ok_o` low.
- R9: `start_i` clears `rec_ok_o`, `mac_ok_o`, `len_o`, `ver_o` and `mac_o` on the next cycle and restarts at offset 0, even in the middle of a record.
- R10: Bytes offered when no read is in progress (after reset before a start, or after done) change no output and raise no done.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new record read at offset 0 |
| byte_i | input | 8 | Record byte |
| byte_vld_i | input | 1 | `byte_i` carries the next record byte this cycle |
| done_o | output | 1 | One-cycle pulse when a read finishes or times out |
| rec_ok_o | output | 1 | Record header passed every check |
| len_o | output | 16 | Captured content length |
| ver_o | output | 24 | Captured version number |
| mac_o | output | 48 | Captured station address, first byte in bits 47:40 |
| mac_ok_o | output | 1 | Station address is usable |

## Verification
A lost or doubled offset step misplaces every later field. It shows up as a wrong `len_o` or `ver_o` within a few beats, and as a `done_o` pulse that comes one beat early or late, which the bench checks to the cycle. A sticky header flag that fails to clear or fails to set first shows in `rec_ok_o` in the done cycle. The bench covers this with records that are mutated one field at a time, each at its exact boundary value. A wrong idle counter shows as a timeout that arrives at the wrong idle cycle, or a read that hangs, after a truncated stream.

// File: rtl/cfg_rec_pkg.sv
package cfg_rec_pkg;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } coll_state_e;

    localparam int MAGIC_BYTES  = 3;
    localparam int LEN_HI_OFS   = 3;
    localparam int LEN_LO_OFS   = 4;
    localparam int VER_FIRST    = 5;
    localparam int VER_LAST     = 7;
    localparam int TYPE_OFS     = 8;
    localparam int HDR_END      = 9;
    localparam int MAC_BYTES    = 6;
    localparam int SLACK_BYTES  = 5;

    function automatic logic version_allowed(input logic [23:0] v);
        return (v == 24'd1) || (v == 24'd2);
    endfunction

endpackage

// File: rtl/cfg_gap_timer.sv
module cfg_gap_timer #(
    parameter int GAP_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = $clog2(GAP_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gap_s;

    gap_s q, d;

    always_comb begin
        d = q;
        if (clear_i || !run_i || tick_i) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
        expire_o = run_i && !tick_i && !clear_i && (q.cnt == CW'(GAP_LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cfg_hdr_check.sv
module cfg_hdr_check
    import cfg_rec_pkg::*;
#(
    parameter logic [23:0] MAGIC      = 24'h434647,
    parameter logic [7:0]  BOARD_TYPE = 8'd2,
    parameter int          MIN_LEN    = 65,
    parameter int          OFS_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [7:0]       byte_i,
    output logic [15:0]      len_o,
    output logic [23:0]      ver_o,
    output logic             hdr_ok_o
);
    typedef struct packed {
        logic        magic_ok;
        logic        type_ok;
        logic [15:0] len;
        logic [23:0] ver;
    } hdr_s;

    hdr_s q, d;
    logic [31:0] ofs_w;
    logic [7:0]  want;

    always_comb begin
        d     = q;
        ofs_w = 32'(ofs_i);
        case (ofs_w)
            32'd0:   want = MAGIC[23:16];
            32'd1:   want = MAGIC[15:8];
            default: want = MAGIC[7:0];
        endcase
        if (clear_i) begin
            d.magic_ok = 1'b1;
            d.type_ok  = 1'b0;
            d.len      = '0;
            d.ver      = '0;
        end else if (take_i) begin
            if (ofs_w < MAGIC_BYTES) begin
                if (byte_i != want) d.magic_ok = 1'b0;
            end
            if (ofs_w == LEN_HI_OFS || ofs_w == LEN_LO_OFS) begin
                d.len = {q.len[7:0], byte_i};
            end
            if (ofs_w >= VER_FIRST && ofs_w <= VER_LAST) begin
                d.ver = {q.ver[15:0], byte_i};
            end
            if (ofs_w == TYPE_OFS) begin
                d.type_ok = (byte_i == BOARD_TYPE);
            end
        end
        len_o    = q.len;
        ver_o    = q.ver;
        hdr_ok_o = q.magic_ok && q.type_ok && (32'(q.len) >= MIN_LEN)
                   && version_allowed(q.ver);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cfg_mac_capture.sv
module cfg_mac_capture
    import cfg_rec_pkg::*;
#(
    parameter int MAC_OFS = 64,
    parameter int OFS_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [7:0]       byte_i,
    output logic [47:0]      mac_o,
    output logic [47:0]      mac_nxt_o
);
    typedef struct packed {
        logic [47:0] mac;
    } mac_s;

    mac_s q, d;
    logic [31:0] ofs_w;
    logic        in_win;

    always_comb begin
        d      = q;
        ofs_w  = 32'(ofs_i);
        in_win = (ofs_w >= MAC_OFS) && (ofs_w < MAC_OFS + MAC_BYTES);
        if (clear_i) begin
            d.mac = '0;
        end else if (take_i && in_win) begin
            d.mac = {q.mac[39:0], byte_i};
        end
        mac_o     = q.mac;
        mac_nxt_o = d.mac;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cfg_record_checker.sv
module cfg_record_checker
    import cfg_rec_pkg::*;
#(
    parameter logic [23:0] MAGIC      = 24'h434647,
    parameter logic [7:0]  BOARD_TYPE = 8'd2,
    parameter int          MAC_OFS    = 64,
    parameter int          GAP_LIMIT  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  byte_i,
    input  logic        byte_vld_i,
    output logic        done_o,
    output logic        rec_ok_o,
    output logic [15:0] len_o,
    output logic [23:0] ver_o,
    output logic [47:0] mac_o,
    output logic        mac_ok_o
);
    localparam int REC_BYTES = MAC_OFS + MAC_BYTES;
    localparam int MIN_LEN   = REC_BYTES - SLACK_BYTES;
    localparam int OFS_W     = $clog2(REC_BYTES + 1);

    typedef struct packed {
        coll_state_e      state;
        logic [OFS_W-1:0] ofs;
        logic             done;
        logic             rec_ok;
        logic             mac_ok;
    } top_s;

    top_s q, d;

    logic        collecting;
    logic        take;
    logic        last;
    logic        expire;
    logic        hdr_ok;
    logic [47:0] mac_nxt;

    assign collecting = (q.state == ST_COLLECT);
    assign take       = collecting && byte_vld_i && !start_i;
    assign last       = take && (q.ofs == OFS_W'(REC_BYTES - 1));

    cfg_hdr_check #(
        .MAGIC      (MAGIC),
        .BOARD_TYPE (BOARD_TYPE),
        .MIN_LEN    (MIN_LEN),
        .OFS_W      (OFS_W)
    ) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .take_i   (take),
        .ofs_i    (q.ofs),
        .byte_i   (byte_i),
        .len_o    (len_o),
        .ver_o    (ver_o),
        .hdr_ok_o (hdr_ok)
    );

    cfg_mac_capture #(
        .MAC_OFS (MAC_OFS),
        .OFS_W   (OFS_W)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .take_i    (take),
        .ofs_i     (q.ofs),
        .byte_i    (byte_i),
        .mac_o     (mac_o),
        .mac_nxt_o (mac_nxt)
    );

    cfg_gap_timer #(
        .GAP_LIMIT (GAP_LIMIT)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .run_i    (collecting),
        .tick_i   (byte_vld_i),
        .expire_o (expire)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.state  = ST_COLLECT;
            d.ofs    = '0;
            d.rec_ok = 1'b0;
            d.mac_ok = 1'b0;
        end else if (take) begin
            d.ofs = q.ofs + OFS_W'(1);
            if (last) begin
                d.state  = ST_IDLE;
                d.done   = 1'b1;
                d.rec_ok = hdr_ok;
                d.mac_ok = hdr_ok && (mac_nxt != '0) && !mac_nxt[40];
            end
        end else if (expire) begin
            d.state  = ST_IDLE;
            d.done   = 1'b1;
            d.rec_ok = 1'b0;
            d.mac_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.ofs    <= '0;
            q.done   <= 1'b0;
            q.rec_ok <= 1'b0;
            q.mac_ok <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done_o   = q.done;
    assign rec_ok_o = q.rec_ok;
    assign mac_ok_o = q.mac_ok;

endmodule

// File: rtl/cfg_record_checker_chk.sv
module cfg_record_checker_chk #(
    parameter int MIN_LEN = 65
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        done_o,
    input logic        rec_ok_o,
    input logic [15:0] len_o,
    input logic [23:0] ver_o,
    input logic [47:0] mac_o,
    input logic        mac_ok_o
);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ok_rises_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_ok_o) |-> done_o);

    assert_ok_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ok_o |-> (32'(len_o) >= MIN_LEN));

    assert_ok_ver_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ok_o |-> (ver_o == 24'd1 || ver_o == 24'd2));

    assert_mac_needs_rec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mac_ok_o |-> (rec_ok_o && mac_o != 48'd0 && !mac_o[40]));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!rec_ok_o && !mac_ok_o && !done_o && len_o == 16'd0 && mac_o == 48'd0));

    assert_verdict_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_ok_o != $past(rec_ok_o)) |-> (done_o || $past(start_i)));

endmodule

bind cfg_record_checker cfg_record_checker_chk u_chk (.*);

// File: tb/cfg_record_checker_test.sv
module cfg_record_checker_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [23:0] MAGIC      = 24'h434647;
    localparam int          MAC_OFS    = 64;
    localparam int          REC_BYTES  = MAC_OFS + 6;
    localparam int          GAP_LIMIT  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic        byte_vld_i = 1'b0;
    logic        done_o, rec_ok_o, mac_ok_o;
    logic [15:0] len_o;
    logic [23:0] ver_o;
    logic [47:0] mac_o;

    int tests = 0;
    int fails = 0;
    logic finished = 1'b0;

    logic [7:0] rec [REC_BYTES];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_record_checker #(
        .MAGIC     (MAGIC),
        .MAC_OFS   (MAC_OFS),
        .GAP_LIMIT (GAP_LIMIT)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .byte_i     (byte_i),
        .byte_vld_i (byte_vld_i),
        .done_o     (done_o),
        .rec_ok_o   (rec_ok_o),
        .len_o      (len_o),
        .ver_o      (ver_o),
        .mac_o      (mac_o),
        .mac_ok_o   (mac_ok_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rec_len();
        return {rec[3], rec[4]};
    endfunction

    function automatic logic [23:0] rec_ver();
        return {rec[5], rec[6], rec[7]};
    endfunction

    function automatic logic [47:0] rec_mac();
        return {rec[MAC_OFS], rec[MAC_OFS+1], rec[MAC_OFS+2],
                rec[MAC_OFS+3], rec[MAC_OFS+4], rec[MAC_OFS+5]};
    endfunction

    function automatic logic exp_ok();
        logic m;
        m = (rec[0] == MAGIC[23:16]) && (rec[1] == MAGIC[15:8]) && (rec[2] == MAGIC[7:0]);
        return m && (int'(rec_len()) >= REC_BYTES - 5)
                 && (rec_ver() == 24'd1 || rec_ver() == 24'd2)
                 && (rec[8] == 8'd2);
    endfunction

    function automatic logic exp_mac_ok();
        logic [47:0] m;
        m = rec_mac();
        return exp_ok() && (m != 48'd0) && !m[40];
    endfunction

    task automatic build_good();
        rec[0] = MAGIC[23:16];
        rec[1] = MAGIC[15:8];
        rec[2] = MAGIC[7:0];
        {rec[3], rec[4]} = 16'($urandom_range(65, 400));
        rec[5] = 8'h00;
        rec[6] = 8'h00;
        rec[7] = 8'($urandom_range(1, 2));
        rec[8] = 8'd2;
        for (int i = 9; i < REC_BYTES; i++) rec[i] = 8'($urandom);
        rec[MAC_OFS] = rec[MAC_OFS] & 8'hFE;
        rec[MAC_OFS+5] = rec[MAC_OFS+5] | 8'h01;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic stream(input int n, input int max_gap);
        for (int i = 0; i < n; i++) begin
            byte_i = rec[i];
            byte_vld_i = 1'b1;
            @(negedge clk);
            byte_vld_i = 1'b0;
            if (i < n - 1) repeat ($urandom_range(0, max_gap)) @(negedge clk);
        end
    endtask

    task automatic run_record(input string req, input int max_gap);
        pulse_start();
        chk({req, " R9 cleared after start"}, {62'd0, rec_ok_o, done_o}, 64'd0);
        stream(REC_BYTES, max_gap);
        chk({req, " R5 done after last byte"}, done_o, 1);
        chk({req, " R1-4 verdict"}, rec_ok_o, exp_ok());
        chk({req, " R7 mac usable"}, mac_ok_o, exp_mac_ok());
        chk({req, " R6 mac value"}, mac_o, rec_mac());
        chk({req, " R2 length"}, len_o, rec_len());
        chk({req, " R3 version"}, ver_o, rec_ver());
        @(negedge clk);
        chk({req, " R5 done single cycle"}, done_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [47:0] hold_mac;
        logic [15:0] hold_len;
        logic        hold_ok;
        int          k;
        void'($urandom(32'h5eed_c0de));

        repeat (3) @(negedge clk);
        chk("R11 reset outputs", {done_o, rec_ok_o, mac_ok_o, len_o, ver_o}, 64'd0);
        chk("R11 reset mac", mac_o, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: bytes with no read active
        build_good();
        stream(12, 0);
        chk("R10 idle bytes ignored len", len_o, 16'd0);
        chk("R10 idle bytes no done", {done_o, rec_ok_o}, 64'd0);

        // directed corner cases
        build_good(); run_record("good", 0);
        build_good(); {rec[3], rec[4]} = 16'd65; run_record("R2 len 65", 1);
        build_good(); {rec[3], rec[4]} = 16'd64; run_record("R2 len 64", 1);
        build_good(); rec[7] = 8'd2; run_record("R3 ver 2", 2);
        build_good(); rec[7] = 8'd3; run_record("R3 ver 3", 2);
        build_good(); rec[6] = 8'd1; rec[7] = 8'd1; run_record("R3 ver 257", 0);
        build_good(); rec[7] = 8'd0; run_record("R3 ver 0", 0);
        build_good(); rec[8] = 8'd1; run_record("R4 type 1", 1);
        build_good(); rec[2] = rec[2] ^ 8'h20; run_record("R1 magic last", 3);
        build_good(); rec[0] = 8'h00; run_record("R1 magic first", 3);
        build_good(); for (int i = 0; i < 6; i++) rec[MAC_OFS+i] = 8'h00;
        run_record("R7 mac zero", 1);
        build_good(); for (int i = 0; i < 5; i++) rec[MAC_OFS+i] = 8'h00;
        rec[MAC_OFS+5] = 8'h01; run_record("R7 mac last byte only", 1);
        build_good(); rec[MAC_OFS] = 8'h01; run_record("R7 mac group bit", 1);
        build_good(); rec[8] = 8'd7; rec[MAC_OFS] = 8'h02; run_record("R7 bad rec good mac", 0);
        build_good();
        for (int i = 9; i < MAC_OFS; i++) rec[i] = 8'hFF;
        run_record("R6 padding ff", 0);

        // R10: bytes after done change nothing
        hold_ok = rec_ok_o; hold_mac = mac_o; hold_len = len_o;
        stream(8, 1);
        @(negedge clk);
        chk("R10 after done verdict", rec_ok_o, hold_ok);
        chk("R10 after done mac", mac_o, hold_mac);
        chk("R10 after done len", len_o, hold_len);
        chk("R10 after done no pulse", done_o, 0);

        // R9: restart mid record
        build_good(); rec[0] = 8'h55;
        pulse_start();
        stream(20, 1);
        pulse_start();
        chk("R9 restart clears len", len_o, 16'd0);
        build_good();
        stream(REC_BYTES, 1);
        chk("R9 restart done", done_o, 1);
        chk("R9 restart verdict", rec_ok_o, 1);
        @(negedge clk);

        // R8: truncated stream times out
        build_good();
        pulse_start();
        stream(30, 2);
        k = 0;
        for (int i = 1; i <= GAP_LIMIT + 4; i++) begin
            @(negedge clk);
            if (done_o && k == 0) k = i;
        end
        chk("R8 timeout cycle", 64'(k), 64'(GAP_LIMIT));
        chk("R8 timeout verdict", {rec_ok_o, mac_ok_o}, 64'd0);

        // random records with field mutations
        for (int n = 0; n < 60; n++) begin
            build_good();
            if ($urandom_range(0, 4) == 0) rec[$urandom_range(0, 2)] = 8'($urandom);
            if ($urandom_range(0, 4) == 0) {rec[3], rec[4]} = 16'($urandom_range(0, 130));
            if ($urandom_range(0, 4) == 0) {rec[5], rec[6], rec[7]} = 24'($urandom_range(0, 3));
            if ($urandom_range(0, 4) == 0) rec[8] = 8'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) rec[MAC_OFS] = rec[MAC_OFS] | 8'h01;
            if ($urandom_range(0, 7) == 0) for (int i = 0; i < 6; i++) rec[MAC_OFS+i] = 8'h00;
            run_record("random", 3);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule